// File: doc/BRIEF.md
# Per-Pixel Reset Count Accumulator

This block collects the one-bit reset decisions that a wide-dynamic-range imager makes for every pixel at each saturation check, and adds them into a small saturating count held for each pixel. That count is the exponent of the final pixel value. One row is handled per check. A row-start strobe names the row and places a single scan token on column 0. Each accepted serial bit then lands in the column that holds the token, and the token moves one column to the right. A one-hot shift register selects the column; there is no column address decoder.

A new check may start only when the row before it has been fully consumed. A ready output signals this. A frame-start pulse zeroes every count. At frame end, a dump request streams all counts in row-major order with a valid strobe, an end-of-row flag and an end-of-frame flag. Any serial bit that arrives while the dump runs is discarded, and a protocol-error pulse reports it. Defaults are 256 columns by 8 rows with 6-bit counts. The full 128-row array is a parameter setting.

Top module: `reset_count_accum`

## Requirements
- R1: An accepted bit of value 1 raises the count of the pixel it addresses by one. A bit of value 0 leaves that count unchanged. A row may be scanned any number of times in a frame.
- R2: An accepted row start places the token on column 0 and latches `row_idx_i`. Each accepted bit is written to the token's column, and the token then moves up by exactly one column. Cycles with `bit_valid_i` low do not move the token.
- R3: `ready_o` is low from the cycle after a row start is accepted until the bit for column NUM_COLS-1 has been accepted. It is high again in the following cycle. A row start or dump request made while `ready_o` is low is ignored.
- R4: A count stays at 2^CNT_W-1 (63 by default) when further 1 bits arrive. It does not wrap.
- R5: A frame-start pulse makes every count read back as zero. A row not yet scanned since the pulse reads zero.
- R6: A dump request accepted while `ready_o` is high and `row_start_i` is low streams the counts. The word with index row*NUM_COLS+col is valid 1+index cycles after the request edge. `ready_o` stays low during the dump.
- R7: `dump_row_end_o` is high on words where col = NUM_COLS-1. `dump_frame_end_o` is high only on the final word. `dump_valid_o` drops after the final word.
- R8: A `bit_valid_i` during an active dump raises `proto_err_o` for one cycle, on the next cycle. That bit changes no count.
- R9: After reset, `ready_o` is high, and `dump_valid_o` and `proto_err_o` are low.
- R10: `bit_valid_i` while no row is being scanned changes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Clears all counts, aborts scan and dump |
| row_start_i | input | 1 | Begins a check on the row given by row_idx_i |
| row_idx_i | input | ROW_W | Row index for the check |
| bit_valid_i | input | 1 | Serial reset bit present |
| bit_i | input | 1 | Serial reset bit for the token's column |
| ready_o | output | 1 | Idle: next check or dump may begin |
| dump_start_i | input | 1 | Starts the frame-end stream |
| dump_valid_o | output | 1 | Stream word valid |
| dump_count_o | output | CNT_W | Count of the streamed pixel |
| dump_row_end_o | output | 1 | Streamed word is the last column of a row |
| dump_frame_end_o | output | 1 | Streamed word is the last of the frame |
| proto_err_o | output | 1 | Bit arrived during a dump |

## Verification
An accepted bit changes the stored count at the next edge. `ready_o` changes one cycle after the accepted row start and one cycle after the last-column bit. Dump word k appears k+1 cycles after the request edge, and the error pulse appears one cycle after the offending bit. The bench runs a behavioural model that moves forward once per clock from the same inputs. The model predicts each output for the cycle after that edge, and the bench compares every output at the falling edge. Every latency above is therefore checked in the exact cycle it is due.

// File: rtl/rca_pkg.sv
package rca_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SCAN = 2'd1,
      PH_DUMP = 2'd2
   } rca_phase_e;

   function automatic int unsigned idx_width(int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rca_col_scanner.sv
module rca_col_scanner #(
   parameter int unsigned NUM_COLS = 256,
   parameter int unsigned COL_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             load_i,
   input  logic             step_i,
   output logic             busy_o,
   output logic             last_o,
   output logic [COL_W-1:0] col_o
);

   logic [NUM_COLS-1:0] token_q;
   logic [NUM_COLS-1:0] token_d;

   // one stage per column: stage 0 takes the load, others take their left neighbour
   for (genvar i = 0; i < NUM_COLS; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_comb begin
            if (clear_i)     token_d[i] = 1'b0;
            else if (load_i) token_d[i] = 1'b1;
            else if (step_i) token_d[i] = 1'b0;
            else             token_d[i] = token_q[i];
         end
      end else begin : g_body
         always_comb begin
            if (clear_i || load_i) token_d[i] = 1'b0;
            else if (step_i)       token_d[i] = token_q[i-1];
            else                   token_d[i] = token_q[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) token_q <= '0;
      else        token_q <= token_d;
   end

   // one-hot to index by OR-ing the position of the set stage
   always_comb begin
      col_o = '0;
      for (int i = 0; i < NUM_COLS; i++) begin
         if (token_q[i]) col_o = col_o | COL_W'(i);
      end
   end

   assign busy_o = |token_q;
   assign last_o = token_q[NUM_COLS-1];

   p_token_onehot_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(token_q));

   p_token_shift_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && step_i && !last_o && !clear_i) |=> (token_q == ($past(token_q) << 1)));

   p_token_drain_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && last_o && !load_i) |=> !busy_o);

endmodule

// File: rtl/rca_count_store.sv
module rca_count_store #(
   parameter int unsigned NUM_ROWS = 8,
   parameter int unsigned NUM_COLS = 256,
   parameter int unsigned CNT_W    = 6,
   parameter int unsigned ROW_W    = 3,
   parameter int unsigned COL_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             wr_i,
   input  logic [ROW_W-1:0] wr_row_i,
   input  logic [COL_W-1:0] wr_col_i,
   input  logic             bit_i,
   input  logic             row_done_i,
   input  logic [ROW_W-1:0] rd_row_i,
   input  logic [COL_W-1:0] rd_col_i,
   output logic [CNT_W-1:0] rd_cnt_o
);

   localparam int unsigned DEPTH = NUM_ROWS * NUM_COLS;
   localparam int unsigned IDX_W = rca_pkg::idx_width(DEPTH);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0]    cells [DEPTH];
   logic [NUM_ROWS-1:0] row_seen_q;
   logic [IDX_W-1:0]    wr_idx;
   logic [IDX_W-1:0]    rd_idx;
   logic [CNT_W-1:0]    old_cnt;
   logic [CNT_W-1:0]    new_cnt;

   assign wr_idx = IDX_W'(wr_row_i) * IDX_W'(NUM_COLS) + IDX_W'(wr_col_i);
   assign rd_idx = IDX_W'(rd_row_i) * IDX_W'(NUM_COLS) + IDX_W'(rd_col_i);

   // rows not yet scanned since frame start count as zero
   assign old_cnt = row_seen_q[wr_row_i] ? cells[wr_idx] : '0;
   assign new_cnt = (bit_i && (old_cnt != CNT_MAX)) ? old_cnt + 1'b1 : old_cnt;
   assign rd_cnt_o = row_seen_q[rd_row_i] ? cells[rd_idx] : '0;

   always_ff @(posedge clk) begin
      if (wr_i && !clear_i) cells[wr_idx] <= new_cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 row_seen_q <= '0;
      else if (clear_i)           row_seen_q <= '0;
      else if (wr_i && row_done_i) row_seen_q[wr_row_i] <= 1'b1;
   end

   p_clear_all_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (row_seen_q == '0));

   p_done_marks_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && row_done_i && !clear_i) |=> row_seen_q[$past(wr_row_i)]);

endmodule

// File: rtl/rca_dump_seq.sv
module rca_dump_seq #(
   parameter int unsigned NUM_ROWS = 8,
   parameter int unsigned NUM_COLS = 256,
   parameter int unsigned ROW_W    = 3,
   parameter int unsigned COL_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             start_i,
   output logic             active_o,
   output logic [ROW_W-1:0] row_o,
   output logic [COL_W-1:0] col_o,
   output logic             row_end_o,
   output logic             frame_end_o
);

   localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

   logic             active_q;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;

   assign row_end_o   = active_q && (col_q == LAST_COL);
   assign frame_end_o = row_end_o && (row_q == LAST_ROW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         row_q    <= '0;
         col_q    <= '0;
      end else if (clear_i) begin
         active_q <= 1'b0;
         row_q    <= '0;
         col_q    <= '0;
      end else if (start_i && !active_q) begin
         active_q <= 1'b1;
         row_q    <= '0;
         col_q    <= '0;
      end else if (active_q) begin
         if (frame_end_o) active_q <= 1'b0;
         if (row_end_o) begin
            col_q <= '0;
            row_q <= row_q + 1'b1;
         end else begin
            col_q <= col_q + 1'b1;
         end
      end
   end

   assign active_o = active_q;
   assign row_o    = row_q;
   assign col_o    = col_q;

   p_dump_stops_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && frame_end_o) |=> !active_q);

   p_dump_walk_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !row_end_o && !clear_i) |=> (col_q == $past(col_q) + 1'b1));

endmodule

// File: rtl/reset_count_accum.sv
module reset_count_accum #(
   parameter int unsigned NUM_COLS = 256,
   parameter int unsigned NUM_ROWS = 8,
   parameter int unsigned CNT_W    = 6,
   localparam int unsigned ROW_W   = rca_pkg::idx_width(NUM_ROWS),
   localparam int unsigned COL_W   = rca_pkg::idx_width(NUM_COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start_i,
   input  logic             row_start_i,
   input  logic [ROW_W-1:0] row_idx_i,
   input  logic             bit_valid_i,
   input  logic             bit_i,
   output logic             ready_o,
   input  logic             dump_start_i,
   output logic             dump_valid_o,
   output logic [CNT_W-1:0] dump_count_o,
   output logic             dump_row_end_o,
   output logic             dump_frame_end_o,
   output logic             proto_err_o
);

   import rca_pkg::*;

   if (NUM_COLS < 2) begin : g_bad_cols
      $error("NUM_COLS must be at least 2");
   end
   if (NUM_ROWS < 2) begin : g_bad_rows
      $error("NUM_ROWS must be at least 2");
   end
   if ((CNT_W < 1) || (CNT_W > 16)) begin : g_bad_cnt
      $error("CNT_W must be within 1..16");
   end

   logic             scan_busy;
   logic             scan_last;
   logic [COL_W-1:0] scan_col;
   logic             dump_active;
   logic [ROW_W-1:0] dump_row;
   logic [COL_W-1:0] dump_col;
   logic [ROW_W-1:0] row_q;
   logic             err_q;
   rca_phase_e       phase;
   logic             accept_row;
   logic             accept_dump;
   logic             take_bit;

   always_comb begin
      if (dump_active)    phase = PH_DUMP;
      else if (scan_busy) phase = PH_SCAN;
      else                phase = PH_IDLE;
   end

   assign ready_o     = (phase == PH_IDLE);
   assign accept_row  = ready_o && row_start_i && !frame_start_i;
   assign accept_dump = ready_o && dump_start_i && !row_start_i && !frame_start_i;
   assign take_bit    = bit_valid_i && (phase == PH_SCAN) && !frame_start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          row_q <= '0;
      else if (accept_row) row_q <= row_idx_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= bit_valid_i && dump_active;
   end

   rca_col_scanner #(
      .NUM_COLS (NUM_COLS),
      .COL_W    (COL_W)
   ) u_scanner (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (frame_start_i),
      .load_i  (accept_row),
      .step_i  (take_bit),
      .busy_o  (scan_busy),
      .last_o  (scan_last),
      .col_o   (scan_col)
   );

   rca_count_store #(
      .NUM_ROWS (NUM_ROWS),
      .NUM_COLS (NUM_COLS),
      .CNT_W    (CNT_W),
      .ROW_W    (ROW_W),
      .COL_W    (COL_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (frame_start_i),
      .wr_i       (take_bit),
      .wr_row_i   (row_q),
      .wr_col_i   (scan_col),
      .bit_i      (bit_i),
      .row_done_i (scan_last),
      .rd_row_i   (dump_row),
      .rd_col_i   (dump_col),
      .rd_cnt_o   (dump_count_o)
   );

   rca_dump_seq #(
      .NUM_ROWS (NUM_ROWS),
      .NUM_COLS (NUM_COLS),
      .ROW_W    (ROW_W),
      .COL_W    (COL_W)
   ) u_dump (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (frame_start_i),
      .start_i     (accept_dump),
      .active_o    (dump_active),
      .row_o       (dump_row),
      .col_o       (dump_col),
      .row_end_o   (dump_row_end_o),
      .frame_end_o (dump_frame_end_o)
   );

   assign dump_valid_o = dump_active;
   assign proto_err_o  = err_q;

   p_midrow_blocked_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (scan_busy && !frame_start_i && !(take_bit && scan_last)) |=> !ready_o);

   p_ready_after_last_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (take_bit && scan_last) |=> ready_o);

   p_scan_dump_exclusive_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !(scan_busy && dump_active));

   p_err_pulse_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (proto_err_o && !bit_valid_i) |=> !proto_err_o);

endmodule

// File: tb/reset_count_accum_tb.sv
module reset_count_accum_tb;

   localparam int COLS = 8;
   localparam int ROWS = 4;
   localparam int CW   = 6;
   localparam int MAXC = (1 << CW) - 1;
   localparam int N    = COLS * ROWS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_start = 1'b0;
   logic          row_start = 1'b0;
   logic [1:0]    row_idx = '0;
   logic          bit_valid = 1'b0;
   logic          bit_v = 1'b0;
   logic          ready;
   logic          dump_start = 1'b0;
   logic          dump_valid;
   logic [CW-1:0] dump_count;
   logic          dump_row_end;
   logic          dump_frame_end;
   logic          proto_err;

   always #2.5 clk = ~clk;

   reset_count_accum #(.NUM_COLS(COLS), .NUM_ROWS(ROWS), .CNT_W(CW)) u_dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .frame_start_i    (frame_start),
      .row_start_i      (row_start),
      .row_idx_i        (row_idx),
      .bit_valid_i      (bit_valid),
      .bit_i            (bit_v),
      .ready_o          (ready),
      .dump_start_i     (dump_start),
      .dump_valid_o     (dump_valid),
      .dump_count_o     (dump_count),
      .dump_row_end_o   (dump_row_end),
      .dump_frame_end_o (dump_frame_end),
      .proto_err_o      (proto_err)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 0;
   string cur_req = "R9";

   // behavioural reference model
   int m_cnt [ROWS][COLS];
   int m_col = -1;
   int m_row = 0;
   bit m_rd  = 0;
   int m_ptr = 0;
   bit m_err = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit exp_ready;
      exp_ready = (m_col < 0) && !m_rd;
      chk(ready == exp_ready, "R3", int'(ready), int'(exp_ready));
      chk(dump_valid == m_rd, "R6", int'(dump_valid), int'(m_rd));
      chk(proto_err == m_err, "R8", int'(proto_err), int'(m_err));
      if (m_rd) begin
         chk(int'(dump_count) == m_cnt[m_ptr / COLS][m_ptr % COLS], cur_req,
             int'(dump_count), m_cnt[m_ptr / COLS][m_ptr % COLS]);
         chk(dump_row_end == ((m_ptr % COLS) == COLS - 1), "R7",
             int'(dump_row_end), int'((m_ptr % COLS) == COLS - 1));
         chk(dump_frame_end == (m_ptr == N - 1), "R7",
             int'(dump_frame_end), int'(m_ptr == N - 1));
      end
   endtask

   task automatic tick();
      bit rdy;
      bit rd_pre;
      rdy    = (m_col < 0) && !m_rd;
      rd_pre = m_rd;
      m_err  = bit_valid && m_rd;
      if (frame_start) begin
         for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) m_cnt[r][c] = 0;
         m_col = -1;
         m_rd  = 0;
      end else begin
         if (rd_pre) begin
            if (m_ptr == N - 1) m_rd = 0;
            else m_ptr++;
         end
         if (bit_valid && !rd_pre && (m_col >= 0)) begin
            if (bit_v && (m_cnt[m_row][m_col] < MAXC)) m_cnt[m_row][m_col]++;
            m_col++;
            if (m_col == COLS) m_col = -1;
         end
         if (rdy && row_start) begin
            m_col = 0;
            m_row = int'(row_idx);
         end else if (rdy && dump_start) begin
            m_rd  = 1;
            m_ptr = 0;
         end
      end
      @(posedge clk);
      @(negedge clk);
      compare_all();
      frame_start = 1'b0;
      row_start   = 1'b0;
      dump_start  = 1'b0;
      bit_valid   = 1'b0;
      bit_v       = 1'b0;
   endtask

   // mode 0: column parity, 1: all ones, 2: all zeros
   task automatic scan_row(input int r, input int mode, input bit gaps);
      row_start = 1'b1;
      row_idx   = 2'(r);
      tick();
      for (int c = 0; c < COLS; c++) begin
         bit_valid = 1'b1;
         bit_v     = (mode == 1) ? 1'b1 : (mode == 0) ? 1'(c % 2) : 1'b0;
         tick();
         if (gaps && (c % 3 == 1)) tick();
      end
   endtask

   task automatic dump_all(input int err_at);
      dump_start = 1'b1;
      tick();
      for (int k = 0; k < N + 1; k++) begin
         if (k == err_at) begin
            bit_valid = 1'b1;
            bit_v     = 1'b1;
         end
         tick();
      end
   endtask

   initial begin
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++) m_cnt[r][c] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R9";
      chk(ready == 1'b1, "R9", int'(ready), 1);
      chk(dump_valid == 1'b0, "R9", int'(dump_valid), 0);
      chk(proto_err == 1'b0, "R9", int'(proto_err), 0);

      cur_req = "R5";
      frame_start = 1'b1;
      tick();

      cur_req = "R2";
      scan_row(1, 0, 1'b1);

      // row start and dump request mid-row are ignored
      cur_req = "R3";
      row_start = 1'b1;
      row_idx   = 2'd0;
      tick();
      for (int c = 0; c < COLS; c++) begin
         if (c == 2) begin
            row_start = 1'b1;
            row_idx   = 2'd3;
         end
         if (c == 4) dump_start = 1'b1;
         bit_valid = 1'b1;
         bit_v     = 1'(c < 3);
         tick();
      end

      cur_req = "R1";
      scan_row(2, 1, 1'b0);
      scan_row(2, 1, 1'b1);
      scan_row(1, 2, 1'b0);

      cur_req = "R10";
      for (int k = 0; k < 3; k++) begin
         bit_valid = 1'b1;
         bit_v     = 1'b1;
         tick();
      end

      cur_req = "R6";
      dump_all(5);

      cur_req = "R4";
      for (int p = 0; p < MAXC + 6; p++) scan_row(3, 1, 1'b0);
      dump_all(N - 1);

      cur_req = "R5";
      frame_start = 1'b1;
      tick();
      dump_all(-1);
      repeat (2) tick();
      done = 1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 100000);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule